// File: doc/BRIEF.md
# Length-Framed I2C Word Register Target

This block is an I2C target that gives a host controller access to a bank of 32-bit registers, each selected by an 8-bit offset. The block watches SCL and SDA through a faster system clock and finds start, repeated-start and stop conditions from the sampled levels. It answers only to its own 7-bit address and drives SDA through an open-drain enable.

Each word transfer carries a byte count of four. To write, the host sends the offset, the count, and then the four data bytes, least significant byte first. The write takes effect at the stop. To read, the host sends the offset in a write-addressed phase and then issues a repeated start. The target then returns the count followed by the four word bytes, least significant byte first.

Two offsets hold fixed identification words, and one offset holds an internal connection-state word. Every other offset is passed to surrounding logic through a register-file port.

Top module: `i2c_word_target`

## Requirements
- R1: The target ACKs an address byte only when its upper seven bits equal `DEV_ADDR`. On any other address it leaves SDA released for the ACK slot and for all following bytes until the next start.
- R2: In a read phase (address bit 0 = 1), the first byte returned is the word length, which is 4.
- R3: After the length byte, the target returns the word selected by the last latched offset byte, least significant byte first.
- R4: A write phase made of the offset, a size byte of 4, four data bytes (LSB first) and a stop updates the selected register. The connection-state word at offset 4 reads back the value written.
- R5: A size byte other than 4 is NACKed, and the frame changes no register.
- R6: A write frame that ends at a stop before all four data bytes have arrived changes no register.
- R7: Offset `VENDOR_OFF` (0) returns `VENDOR_ID` and offset `DEVICE_OFF` (1) returns `DEVICE_ID`. Writes to these two offsets are discarded.
- R8: Any offset other than 0, 1 and 4 reads `regRdData` while `regRdOffset` holds that offset. A committed write to such an offset gives a one-cycle `regWrStrobe` with `regWrOffset` and `regWrData`.
- R9: The target pulls SDA only low, and it changes its SDA drive only while SCL is low. It releases SDA after each byte it sends, and a host NACK ends the read with SDA released.
- R10: Write bytes after the fourth data byte are NACKed, and the first four still commit at the stop. Read bytes after the fourth data byte return 8'hFF.
- R11: After reset, SDA is released and no write strobe is raised.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock that oversamples the bus |
| rstN | input | 1 | Active-low reset |
| sclIn | input | 1 | Sampled SCL line level |
| sdaIn | input | 1 | Sampled SDA line level |
| sdaOe | output | 1 | High to pull SDA low |
| regRdOffset | output | 8 | Latched offset presented to the register file |
| regRdData | input | 32 | Register-file read data for `regRdOffset` |
| regWrStrobe | output | 1 | One-cycle write strobe to the register file |
| regWrOffset | output | 8 | Offset for the write |
| regWrData | output | 32 | Word for the write |

## Verification
The bench keeps the default four-byte word and the two-stage synchronizer. It overrides the device address to 7'h31 and the two identification words, so a wrong address (7'h30) differs from the real one only in its lowest bit. Because the identification words are non-default and asymmetric, any byte-order error in the length-prefixed read shows up as a wrong value. With a 40-cycle SCL bit period, the synchronizer delay stays well inside each SCL phase, so the ACK and data-bit timing is checked with margin on both sides.

// File: rtl/i2cw_pkg.sv
package i2cw_pkg;

  // width of the byte index carried between control and datapath
  localparam int IDX_W = 4;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_RX,
    ST_ACK_TX,
    ST_TX,
    ST_ACK_RX
  } busState_e;

  typedef struct packed {
    logic             rxBit;
    logic             rxShift;
    logic             offsetLoad;
    logic             dataLoad;
    logic             snapLoad;
    logic             txLoad;
    logic             txShift;
    logic             commit;
    logic [IDX_W-1:0] byteIdx;
  } dpStrobe_t;

endpackage

// File: rtl/i2cw_ctrl.sv
module i2cw_ctrl
  import i2cw_pkg::*;
#(
  parameter logic [6:0] DEV_ADDR    = 7'h2A,
  parameter int         WORD_BYTES  = 4,
  parameter int         SYNC_STAGES = 2
) (
  input  logic       clk,
  input  logic       rstN,
  input  logic       sclIn,
  input  logic       sdaIn,
  input  logic [7:0] rxByte,
  input  logic       txBit,
  output dpStrobe_t  strobe,
  output logic       sdaOe
);

  localparam int LAST_WR_IDX = WORD_BYTES + 1;

  logic [SYNC_STAGES-1:0] sclSync, sdaSync;
  logic scl, sda, sclPrev, sdaPrev;
  logic sclRise, sclFall, startDet, stopDet;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      sclSync <= '1;
      sdaSync <= '1;
      sclPrev <= 1'b1;
      sdaPrev <= 1'b1;
    end else begin
      sclSync <= {sclSync[SYNC_STAGES-2:0], sclIn};
      sdaSync <= {sdaSync[SYNC_STAGES-2:0], sdaIn};
      sclPrev <= scl;
      sdaPrev <= sda;
    end
  end

  assign scl      = sclSync[SYNC_STAGES-1];
  assign sda      = sdaSync[SYNC_STAGES-1];
  assign sclRise  = scl & ~sclPrev;
  assign sclFall  = ~scl & sclPrev;
  assign startDet = scl & sclPrev & sdaPrev & ~sda;
  assign stopDet  = scl & sclPrev & ~sdaPrev & sda;

  busState_e        state, stateN;
  logic [2:0]       bitCnt, bitCntN;
  logic             byteRdy, byteRdyN;
  logic             inAddr, inAddrN;
  logic             isRead, isReadN;
  logic [IDX_W-1:0] idx, idxN;
  logic             ackDrive, ackDriveN;
  logic             hostAck, hostAckN;
  logic             wrFull, wrFullN;
  logic             ackOk;
  logic             addrMiss;

  assign addrMiss = (state == ST_RX) && sclFall && byteRdy && inAddr &&
                    (rxByte[7:1] != DEV_ADDR);

  always_comb begin
    stateN    = state;
    bitCntN   = bitCnt;
    byteRdyN  = byteRdy;
    inAddrN   = inAddr;
    isReadN   = isRead;
    idxN      = idx;
    ackDriveN = ackDrive;
    hostAckN  = hostAck;
    wrFullN   = wrFull;
    ackOk     = 1'b0;
    strobe    = '0;
    strobe.rxBit   = sda;
    strobe.byteIdx = idx;
    if (startDet) begin
      stateN    = ST_RX;
      bitCntN   = '0;
      byteRdyN  = 1'b0;
      inAddrN   = 1'b1;
      isReadN   = 1'b0;
      idxN      = '0;
      ackDriveN = 1'b0;
      wrFullN   = 1'b0;
    end else if (stopDet) begin
      strobe.commit = wrFull & ~isRead;
      stateN    = ST_IDLE;
      ackDriveN = 1'b0;
      wrFullN   = 1'b0;
    end else begin
      unique case (state)
        ST_RX: begin
          if (sclRise) begin
            strobe.rxShift = 1'b1;
            bitCntN = bitCnt + 3'd1;
            if (bitCnt == 3'd7) byteRdyN = 1'b1;
          end else if (sclFall && byteRdy) begin
            byteRdyN = 1'b0;
            bitCntN  = '0;
            if (inAddr) begin
              inAddrN = 1'b0;
              if (rxByte[7:1] == DEV_ADDR) begin
                ackOk           = 1'b1;
                isReadN         = rxByte[0];
                idxN            = '0;
                strobe.snapLoad = rxByte[0];
              end
            end else if (idx == '0) begin
              ackOk             = 1'b1;
              strobe.offsetLoad = 1'b1;
              idxN              = idx + 1'b1;
            end else if (idx == IDX_W'(1)) begin
              ackOk = (rxByte == 8'(WORD_BYTES));
              idxN  = idx + 1'b1;
            end else if (idx <= IDX_W'(LAST_WR_IDX)) begin
              ackOk           = 1'b1;
              strobe.dataLoad = 1'b1;
              strobe.byteIdx  = idx - IDX_W'(2);
              idxN            = idx + 1'b1;
              if (idx == IDX_W'(LAST_WR_IDX)) wrFullN = 1'b1;
            end
            if (ackOk) begin
              stateN    = ST_ACK_TX;
              ackDriveN = 1'b1;
            end else begin
              stateN = ST_IDLE;
            end
          end
        end
        ST_ACK_TX: begin
          if (sclFall) begin
            ackDriveN = 1'b0;
            bitCntN   = '0;
            if (isRead) begin
              stateN         = ST_TX;
              strobe.txLoad  = 1'b1;
              strobe.byteIdx = idx;
            end else begin
              stateN = ST_RX;
            end
          end
        end
        ST_TX: begin
          if (sclFall) begin
            if (bitCnt == 3'd7) begin
              stateN  = ST_ACK_RX;
              bitCntN = '0;
            end else begin
              strobe.txShift = 1'b1;
              bitCntN = bitCnt + 3'd1;
            end
          end
        end
        ST_ACK_RX: begin
          if (sclRise) begin
            hostAckN = ~sda;
          end else if (sclFall) begin
            if (hostAck) begin
              stateN         = ST_TX;
              bitCntN        = '0;
              idxN           = (idx == '1) ? idx : idx + 1'b1;
              strobe.txLoad  = 1'b1;
              strobe.byteIdx = (idx == '1) ? idx : idx + 1'b1;
            end else begin
              stateN = ST_IDLE;
            end
          end
        end
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state    <= ST_IDLE;
      bitCnt   <= '0;
      byteRdy  <= 1'b0;
      inAddr   <= 1'b0;
      isRead   <= 1'b0;
      idx      <= '0;
      ackDrive <= 1'b0;
      hostAck  <= 1'b0;
      wrFull   <= 1'b0;
    end else begin
      state    <= stateN;
      bitCnt   <= bitCntN;
      byteRdy  <= byteRdyN;
      inAddr   <= inAddrN;
      isRead   <= isReadN;
      idx      <= idxN;
      ackDrive <= ackDriveN;
      hostAck  <= hostAckN;
      wrFull   <= wrFullN;
    end
  end

  assign sdaOe = ackDrive | ((state == ST_TX) & ~txBit);

  AST_SDA_SCL_LOW: assert property (@(posedge clk) disable iff (!rstN)
    !$stable(sdaOe) |-> !scl); // R9

  AST_NACK_UNSELECTED: assert property (@(posedge clk) disable iff (!rstN)
    addrMiss |=> (!sdaOe && state == ST_IDLE)); // R1

  AST_ONE_STROBE: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0({strobe.rxShift, strobe.offsetLoad, strobe.dataLoad, strobe.snapLoad,
              strobe.txLoad, strobe.txShift, strobe.commit})); // R4

endmodule

// File: rtl/i2cw_dpath.sv
module i2cw_dpath
  import i2cw_pkg::*;
#(
  parameter int                      WORD_BYTES = 4,
  parameter logic [WORD_BYTES*8-1:0] VENDOR_ID  = 32'h1D5C_0A11,
  parameter logic [WORD_BYTES*8-1:0] DEVICE_ID  = 32'h0000_7E21,
  parameter logic [7:0]              VENDOR_OFF = 8'd0,
  parameter logic [7:0]              DEVICE_OFF = 8'd1,
  parameter logic [7:0]              CONN_OFF   = 8'd4,
  localparam int                     WORD_W     = WORD_BYTES * 8
) (
  input  logic              clk,
  input  logic              rstN,
  input  dpStrobe_t         strobe,
  output logic [7:0]        rxByte,
  output logic              txBit,
  output logic [7:0]        regRdOffset,
  input  logic [WORD_W-1:0] regRdData,
  output logic              regWrStrobe,
  output logic [7:0]        regWrOffset,
  output logic [WORD_W-1:0] regWrData
);

  logic [7:0]        offsetReg;
  logic [WORD_W-1:0] wrWord, snapWord, connReg, curWord;
  logic [7:0]        txShift, txSel;
  logic              isId, isConn;

  assign isId   = (offsetReg == VENDOR_OFF) || (offsetReg == DEVICE_OFF);
  assign isConn = (offsetReg == CONN_OFF);
  assign regRdOffset = offsetReg;
  assign txBit = txShift[7];

  always_comb begin
    if (offsetReg == VENDOR_OFF)      curWord = VENDOR_ID;
    else if (offsetReg == DEVICE_OFF) curWord = DEVICE_ID;
    else if (isConn)                  curWord = connReg;
    else                              curWord = regRdData;
  end

  always_comb begin
    txSel = 8'hFF;
    if (strobe.byteIdx == '0) txSel = 8'(WORD_BYTES);
    for (int k = 0; k < WORD_BYTES; k++) begin
      if (strobe.byteIdx == IDX_W'(k + 1)) txSel = snapWord[k*8 +: 8];
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      rxByte    <= '0;
      offsetReg <= '0;
      snapWord  <= '0;
      txShift   <= 8'hFF;
    end else begin
      if (strobe.rxShift)    rxByte    <= {rxByte[6:0], strobe.rxBit};
      if (strobe.offsetLoad) offsetReg <= rxByte;
      if (strobe.snapLoad)   snapWord  <= curWord;
      if (strobe.txLoad)       txShift <= txSel;
      else if (strobe.txShift) txShift <= {txShift[6:0], 1'b1};
    end
  end

  for (genvar g = 0; g < WORD_BYTES; g++) begin : g_wrByte
    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN) wrWord[g*8 +: 8] <= '0;
      else if (strobe.dataLoad && strobe.byteIdx == IDX_W'(g))
        wrWord[g*8 +: 8] <= rxByte;
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      connReg     <= '0;
      regWrStrobe <= 1'b0;
      regWrOffset <= '0;
      regWrData   <= '0;
    end else begin
      regWrStrobe <= strobe.commit && !isId && !isConn;
      if (strobe.commit && isConn) connReg <= wrWord;
      if (strobe.commit) begin
        regWrOffset <= offsetReg;
        regWrData   <= wrWord;
      end
    end
  end

  AST_WR_SINGLE: assert property (@(posedge clk) disable iff (!rstN)
    regWrStrobe |=> !regWrStrobe); // R8

  AST_ID_NO_WRITE: assert property (@(posedge clk) disable iff (!rstN)
    regWrStrobe |-> (regWrOffset != VENDOR_OFF && regWrOffset != DEVICE_OFF &&
                     regWrOffset != CONN_OFF)); // R7

endmodule

// File: rtl/i2c_word_target.sv
module i2c_word_target
  import i2cw_pkg::*;
#(
  parameter logic [6:0]              DEV_ADDR    = 7'h2A,
  parameter int                      WORD_BYTES  = 4,
  parameter int                      SYNC_STAGES = 2,
  parameter logic [WORD_BYTES*8-1:0] VENDOR_ID   = 32'h1D5C_0A11,
  parameter logic [WORD_BYTES*8-1:0] DEVICE_ID   = 32'h0000_7E21,
  parameter logic [7:0]              VENDOR_OFF  = 8'd0,
  parameter logic [7:0]              DEVICE_OFF  = 8'd1,
  parameter logic [7:0]              CONN_OFF    = 8'd4,
  localparam int                     WORD_W      = WORD_BYTES * 8
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              sclIn,
  input  logic              sdaIn,
  output logic              sdaOe,
  output logic [7:0]        regRdOffset,
  input  logic [WORD_W-1:0] regRdData,
  output logic              regWrStrobe,
  output logic [7:0]        regWrOffset,
  output logic [WORD_W-1:0] regWrData
);

  dpStrobe_t  strobe;
  logic [7:0] rxByte;
  logic       txBit;

  i2cw_ctrl #(
    .DEV_ADDR   (DEV_ADDR),
    .WORD_BYTES (WORD_BYTES),
    .SYNC_STAGES(SYNC_STAGES)
  ) u_ctrl (
    .clk   (clk),
    .rstN  (rstN),
    .sclIn (sclIn),
    .sdaIn (sdaIn),
    .rxByte(rxByte),
    .txBit (txBit),
    .strobe(strobe),
    .sdaOe (sdaOe)
  );

  i2cw_dpath #(
    .WORD_BYTES(WORD_BYTES),
    .VENDOR_ID (VENDOR_ID),
    .DEVICE_ID (DEVICE_ID),
    .VENDOR_OFF(VENDOR_OFF),
    .DEVICE_OFF(DEVICE_OFF),
    .CONN_OFF  (CONN_OFF)
  ) u_dpath (
    .clk        (clk),
    .rstN       (rstN),
    .strobe     (strobe),
    .rxByte     (rxByte),
    .txBit      (txBit),
    .regRdOffset(regRdOffset),
    .regRdData  (regRdData),
    .regWrStrobe(regWrStrobe),
    .regWrOffset(regWrOffset),
    .regWrData  (regWrData)
  );

endmodule

// File: tb/i2c_word_target_bench.sv
module i2c_word_target_bench;

  localparam logic [6:0]  ADDR  = 7'h31;
  localparam logic [31:0] VID   = 32'hA5C3_1E07;
  localparam logic [31:0] DID   = 32'h0000_3B42;
  localparam int          Q     = 10;

  localparam logic [39:0] VEC [5] = '{
    40'h04_1234_5678,
    40'h07_DEAD_BEEF,
    40'h04_0000_00A5,
    40'h02_8000_0001,
    40'h09_FFFF_FFFF
  };

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        scl = 1'b1;
  logic        hostLow = 1'b0;
  logic        sdaLine;
  logic        sdaOe;
  logic [7:0]  regRdOffset;
  logic [31:0] regRdData;
  logic        regWrStrobe;
  logic [7:0]  regWrOffset;
  logic [31:0] regWrData;

  logic [31:0] extMem [16];
  int          wrCount = 0;
  int          total = 0;
  int          bad = 0;
  bit          done = 1'b0;
  logic [7:0]  rdBuf [8];
  logic        ackLog [8];

  always #4 clk = ~clk;

  assign sdaLine   = !(hostLow || sdaOe);
  assign regRdData = extMem[regRdOffset[3:0]];

  always_ff @(posedge clk) begin
    if (regWrStrobe) begin
      extMem[regWrOffset[3:0]] <= regWrData;
      wrCount <= wrCount + 1;
    end
  end

  i2c_word_target #(
    .DEV_ADDR (ADDR),
    .VENDOR_ID(VID),
    .DEVICE_ID(DID)
  ) u_i2c_word_target (
    .clk        (clk),
    .rstN       (rstN),
    .sclIn      (scl),
    .sdaIn      (sdaLine),
    .sdaOe      (sdaOe),
    .regRdOffset(regRdOffset),
    .regRdData  (regRdData),
    .regWrStrobe(regWrStrobe),
    .regWrOffset(regWrOffset),
    .regWrData  (regWrData)
  );

  task automatic chk(input bit ok, input string tag, input logic [31:0] act,
                     input logic [31:0] exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic waitQ();
    repeat (Q) @(negedge clk);
  endtask

  task automatic bitOut(input logic b);
    scl = 1'b0; waitQ();
    hostLow = ~b; waitQ();
    scl = 1'b1; waitQ(); waitQ();
    scl = 1'b0;
  endtask

  task automatic bitIn(output logic b);
    scl = 1'b0; waitQ();
    hostLow = 1'b0; waitQ();
    scl = 1'b1; waitQ();
    b = sdaLine; waitQ();
    scl = 1'b0;
  endtask

  task automatic busStart();
    scl = 1'b0; waitQ();
    hostLow = 1'b0; waitQ();
    scl = 1'b1; waitQ();
    hostLow = 1'b1; waitQ();
    scl = 1'b0; waitQ();
  endtask

  task automatic busStop();
    scl = 1'b0; waitQ();
    hostLow = 1'b1; waitQ();
    scl = 1'b1; waitQ();
    hostLow = 1'b0; waitQ(); waitQ();
  endtask

  task automatic sendByte(input logic [7:0] v, output logic acked);
    logic b;
    for (int i = 7; i >= 0; i--) bitOut(v[i]);
    bitIn(b);
    acked = ~b;
  endtask

  task automatic recvByte(input logic giveAck, output logic [7:0] v);
    logic b;
    for (int i = 7; i >= 0; i--) begin
      bitIn(b);
      v[i] = b;
    end
    bitOut(~giveAck);
  endtask

  // write: offset, size, nData bytes of data (LSB first); acks into ackLog
  task automatic doWrite(input logic [7:0] off, input logic [7:0] size,
                         input logic [39:0] data, input int nData);
    logic a;
    busStart();
    sendByte({ADDR, 1'b0}, a); ackLog[0] = a;
    sendByte(off, a);          ackLog[1] = a;
    sendByte(size, a);         ackLog[2] = a;
    for (int i = 0; i < nData; i++) begin
      sendByte(data[i*8 +: 8], a);
      ackLog[3+i] = a;
    end
    busStop();
    repeat (4) @(negedge clk);
  endtask

  task automatic doRead(input logic [7:0] off, input int n);
    logic a;
    busStart();
    sendByte({ADDR, 1'b0}, a);
    sendByte(off, a);
    busStart();
    sendByte({ADDR, 1'b1}, a); ackLog[0] = a;
    for (int i = 0; i < n; i++) recvByte(i < n - 1, rdBuf[i]);
    busStop();
  endtask

  function automatic logic [31:0] rdWord();
    return {rdBuf[4], rdBuf[3], rdBuf[2], rdBuf[1]};
  endfunction

  initial begin
    repeat (180000) @(posedge clk);
    if (!done) begin
      total++;
      bad++;
      $display("FAIL watchdog actual=%h expected=%h", 32'd0, 32'd1);
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    logic a, b;
    int   cnt0;
    for (int i = 0; i < 16; i++) extMem[i] = 32'h0;
    repeat (5) @(negedge clk);
    // R11 reset state
    chk(sdaOe == 1'b0, "R11 sdaOe in reset", {31'd0, sdaOe}, 32'd0);
    rstN = 1'b1;
    repeat (5) @(negedge clk);
    chk(sdaOe == 1'b0 && regWrStrobe == 1'b0, "R11 idle after reset",
        {30'd0, sdaOe, regWrStrobe}, 32'd0);

    // vector table: write then read back
    foreach (VEC[i]) begin
      cnt0 = wrCount;
      doWrite(VEC[i][39:32], 8'd4, {8'h00, VEC[i][31:0]}, 4);
      chk(ackLog[0] && ackLog[1] && ackLog[2] && ackLog[3] && ackLog[6],
          "R4 write acks", {31'd0, ackLog[6]}, 32'd1);
      if (VEC[i][39:32] == 8'd4)
        chk(wrCount == cnt0, "R8 conn write stays internal", wrCount, cnt0);
      else
        chk(wrCount == cnt0 + 1, "R8 one strobe per write", wrCount, cnt0 + 1);
      doRead(VEC[i][39:32], 5);
      chk(ackLog[0], "R2 read address ack", {31'd0, ackLog[0]}, 32'd1);
      chk(rdBuf[0] == 8'd4, "R2 length byte", {24'd0, rdBuf[0]}, 32'd4);
      chk(rdWord() == VEC[i][31:0], "R3 R4 readback", rdWord(), VEC[i][31:0]);
    end

    // R7 identification words
    doRead(8'd0, 5);
    chk(rdWord() == VID, "R7 vendor id", rdWord(), VID);
    doRead(8'd1, 5);
    chk(rdWord() == DID, "R7 device id", rdWord(), DID);
    cnt0 = wrCount;
    doWrite(8'd0, 8'd4, 40'h00_0000_0000, 4);
    doRead(8'd0, 5);
    chk(rdWord() == VID && wrCount == cnt0, "R7 vendor write ignored", rdWord(), VID);

    // R5 bad size byte
    doWrite(8'd4, 8'd3, 40'h00_1111_2222, 4);
    chk(ackLog[2] == 1'b0, "R5 size nack", {31'd0, ackLog[2]}, 32'd0);
    doRead(8'd4, 5);
    chk(rdWord() == 32'h0000_00A5, "R5 no update", rdWord(), 32'h0000_00A5);

    // R6 short frame
    doWrite(8'd4, 8'd4, 40'h00_0033_4455, 3);
    doRead(8'd4, 5);
    chk(rdWord() == 32'h0000_00A5, "R6 short frame no update", rdWord(), 32'h0000_00A5);

    // R1 wrong address
    busStart();
    sendByte({7'h30, 1'b0}, a);
    chk(a == 1'b0, "R1 unselected nack", {31'd0, a}, 32'd0);
    sendByte(8'h00, a);
    chk(a == 1'b0, "R1 off bus after nack", {31'd0, a}, 32'd0);
    busStop();

    // R10 extra write byte, then read past the word
    doWrite(8'd4, 8'd4, 40'h77_CAFE_F00D, 5);
    chk(ackLog[7] == 1'b0, "R10 extra byte nack", {31'd0, ackLog[7]}, 32'd0);
    doRead(8'd4, 6);
    chk(rdWord() == 32'hCAFE_F00D, "R10 first four commit", rdWord(), 32'hCAFE_F00D);
    chk(rdBuf[5] == 8'hFF, "R10 read past word", {24'd0, rdBuf[5]}, 32'hFF);

    // R9 host NACK ends read, SDA released
    busStart();
    sendByte({ADDR, 1'b0}, a);
    sendByte(8'd1, a);
    busStart();
    sendByte({ADDR, 1'b1}, a);
    recvByte(1'b1, rdBuf[0]);
    recvByte(1'b0, rdBuf[1]);
    chk(rdBuf[1] == DID[7:0], "R9 byte before nack", {24'd0, rdBuf[1]}, {24'd0, DID[7:0]});
    bitIn(b);
    chk(b == 1'b1 && sdaOe == 1'b0, "R9 released after nack", {31'd0, b}, 32'd1);
    busStop();

    done = 1'b1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule